// File: doc/BRIEF.md
# External Bus Sequencer with Reset-Aware Arbitration and Refresh Timing

This block sequences the external bus of a chip. It picks which internal requester gets the next external cycle: the DMA engine or the CPU line fill. Either requester may ask for a single longword or for a four-beat burst. The block also hands the whole bus to an outside requester through a release handshake, and it raises refresh cycles for dynamic memory from an interval counter with a programmable limit. The memory side is abstract. Every beat, and every refresh cycle, finishes when the memory returns one acknowledge pulse.

The two resets behave differently. Power-on reset silences every strobe in the same cycle it is asserted and restores the refresh limit register. Manual reset keeps the register contents. It lets a cycle already in progress finish, and it cuts a burst short after the beat in flight. It starts no new internal access and stops the refresh counter. Release requests are still honoured in master mode during manual reset. While the memory is in self-refresh, the block holds off release requests.

Top module: `xbus_ctrl`

## Requirements
- R1: While `por` is high, `cyc_on`, `cyc_dma`, `rfsh_on` and `rel_ack` are 0 in that same cycle, whatever cycle was under way. `beat_no` reads 0.
- R2: With `slave_mode`=1, `drv_en` falls in the same cycle that `por` rises. `drv_en` is also 0 while the bus is released.
- R3: `cmp_q` (refresh limit, written by `cfg_we`/`cfg_wdata`) returns to `RFSH_DEF` only on `por`. Manual reset leaves it unchanged.
- R4: A cycle under way when `mrst` rises continues until its acknowledge. No internal access starts while `mrst` is high.
- R5: If `mrst` is high when a burst beat is acknowledged, the burst ends there and no further beats are issued.
- R6: The refresh counter does not advance while `mrst` is high, so no refresh becomes pending during it.
- R7: The counter runs from 0 and, one clock after it reaches `cmp_q`, clears and marks a refresh pending. From idle, a pending refresh starts a refresh cycle (`rfsh_on`=1) ahead of any internal request. The refresh cycle ends on `mem_ack`.
- R8: `beat_no` counts 0,1,2,3 over a burst, advancing only on `mem_ack`. A single access ends on its first acknowledge.
- R9: Grants are decided only from idle, in this order: release, refresh, DMA (`cyc_dma`=1), CPU (`cyc_dma`=0).
- R10: In master mode (`slave_mode`=0), `brq` releases the bus even while `mrst` is high. `rel_ack` is 0 whenever `mrst` is high. The bus stays released until `brq` falls.
- R11: `brq` is not accepted while `self_ref` is high, nor in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| mrst | input | 1 | Manual reset, active high |
| slave_mode | input | 1 | 1 = slave arbitration mode, 0 = master |
| dma_req | input | 1 | DMA access request |
| dma_burst | input | 1 | DMA request is a four-beat burst |
| cpu_req | input | 1 | CPU line-fill access request |
| cpu_burst | input | 1 | CPU request is a four-beat burst |
| brq | input | 1 | External bus release request |
| self_ref | input | 1 | Memory is in self-refresh |
| mem_ack | input | 1 | Memory acknowledges current beat or refresh |
| cfg_we | input | 1 | Write strobe for the refresh limit |
| cfg_wdata | input | CW | Refresh limit write data |
| cyc_on | output | 1 | Internal access cycle strobe |
| cyc_dma | output | 1 | Current access belongs to DMA |
| beat_no | output | 2 | Beat index within the access |
| rfsh_on | output | 1 | Refresh cycle strobe |
| drv_en | output | 1 | Bus output driver enable |
| rel_ack | output | 1 | Bus release acknowledge |
| cmp_q | output | CW | Refresh limit register |

## Verification
A corrupted sequencer state shows at the strobes on the very next clock. A stuck transfer state keeps `cyc_on` high past its last acknowledge. A wrong beat count shows in `beat_no` or as a fifth beat. A refresh counter that is off by one, or that keeps running under manual reset, makes `rfsh_on` appear early or late by at least one clock in the first refresh period after the fault. A reference model stepped on every edge exposes any of these within one cycle of the divergence.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_RFSH = 2'd2,
        ST_REL  = 2'd3
    } seq_st_t;

    typedef struct packed {
        logic own_dma;
        logic burst;
    } xfer_ctx_t;

    function automatic logic release_ok(input logic brq, input logic slave_mode,
                                        input logic self_ref);
        return brq && !slave_mode && !self_ref;
    endfunction

endpackage

// File: rtl/xbus_rfsh_timer.sv
module xbus_rfsh_timer #(
    parameter int          CW       = 8,
    parameter logic [CW-1:0] RFSH_DEF = 8'd40
) (
    input  logic          clk,
    input  logic          por,
    input  logic          mrst,
    input  logic          take,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_wdata,
    output logic          pend,
    output logic [CW-1:0] cmp_q
);
    logic [CW-1:0] cnt_q;
    logic          pend_q;

    always_ff @(posedge clk) begin
        if (por) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            cmp_q  <= RFSH_DEF;
        end else begin
            if (cfg_we)
                cmp_q <= cfg_wdata;
            if (!mrst && cnt_q >= cmp_q) begin
                cnt_q  <= '0;
                pend_q <= 1'b1;
            end else begin
                if (!mrst)
                    cnt_q <= cnt_q + 1'b1;
                if (take)
                    pend_q <= 1'b0;
            end
        end
    end

    assign pend = pend_q;

    p_cnt_frozen_r6: assert property (@(posedge clk) disable iff (por)
        mrst |=> $stable(cnt_q));
    p_pend_hold_r6: assert property (@(posedge clk) disable iff (por)
        (mrst && !pend_q) |=> !pend_q);

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int BEATS = 4,
    localparam int BW = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          por,
    input  logic          mrst,
    input  logic          slave_mode,
    input  logic          dma_req,
    input  logic          dma_burst,
    input  logic          cpu_req,
    input  logic          cpu_burst,
    input  logic          brq,
    input  logic          self_ref,
    input  logic          mem_ack,
    input  logic          rf_pend,
    output logic          rf_take,
    output seq_st_t       st,
    output xfer_ctx_t     ctx,
    output logic [BW-1:0] beat
);
    localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

    seq_st_t       st_q, st_n;
    xfer_ctx_t     ctx_q, ctx_n;
    logic [BW-1:0] beat_q, beat_n;
    logic          rel_go;

    assign rel_go = release_ok(brq, slave_mode, self_ref);

    always_comb begin
        st_n    = st_q;
        ctx_n   = ctx_q;
        beat_n  = beat_q;
        rf_take = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (rel_go) begin
                    st_n = ST_REL;
                end else if (rf_pend) begin
                    st_n    = ST_RFSH;
                    rf_take = 1'b1;
                end else if (!mrst && dma_req) begin
                    st_n   = ST_XFER;
                    ctx_n  = '{own_dma: 1'b1, burst: dma_burst};
                    beat_n = '0;
                end else if (!mrst && cpu_req) begin
                    st_n   = ST_XFER;
                    ctx_n  = '{own_dma: 1'b0, burst: cpu_burst};
                    beat_n = '0;
                end
            end
            ST_XFER: begin
                if (mem_ack) begin
                    if (ctx_q.burst && beat_q != LAST && !mrst) begin
                        beat_n = beat_q + 1'b1;
                    end else begin
                        st_n   = ST_IDLE;
                        beat_n = '0;
                    end
                end
            end
            ST_RFSH: if (mem_ack) st_n = ST_IDLE;
            ST_REL:  if (!brq)    st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por) begin
            st_q   <= ST_IDLE;
            ctx_q  <= '0;
            beat_q <= '0;
        end else begin
            st_q   <= st_n;
            ctx_q  <= ctx_n;
            beat_q <= beat_n;
        end
    end

    assign st   = st_q;
    assign ctx  = ctx_q;
    assign beat = beat_q;

    p_no_start_mrst_r4: assert property (@(posedge clk) disable iff (por)
        (st_q == ST_IDLE && mrst) |=> st_q != ST_XFER);
    p_burst_cut_r5: assert property (@(posedge clk) disable iff (por)
        (st_q == ST_XFER && mrst && mem_ack) |=> st_q == ST_IDLE);
    p_beat_hold_r8: assert property (@(posedge clk) disable iff (por)
        (st_q == ST_XFER && !mem_ack) |=> ($stable(beat_q) && st_q == ST_XFER));
    p_selfref_hold_r11: assert property (@(posedge clk) disable iff (por)
        (st_q == ST_IDLE && self_ref) |=> st_q != ST_REL);

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int            CW       = 8,
    parameter logic [CW-1:0] RFSH_DEF = 8'd40
) (
    input  logic          clk,
    input  logic          por,
    input  logic          mrst,
    input  logic          slave_mode,
    input  logic          dma_req,
    input  logic          dma_burst,
    input  logic          cpu_req,
    input  logic          cpu_burst,
    input  logic          brq,
    input  logic          self_ref,
    input  logic          mem_ack,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_wdata,
    output logic          cyc_on,
    output logic          cyc_dma,
    output logic [1:0]    beat_no,
    output logic          rfsh_on,
    output logic          drv_en,
    output logic          rel_ack,
    output logic [CW-1:0] cmp_q
);
    localparam int BEATS = 4;
    localparam int BW    = $clog2(BEATS);

    logic          rf_pend, rf_take;
    seq_st_t       st;
    xfer_ctx_t     ctx;
    logic [BW-1:0] beat;

    xbus_rfsh_timer #(.CW(CW), .RFSH_DEF(RFSH_DEF)) u_timer (
        .clk(clk), .por(por), .mrst(mrst), .take(rf_take),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .pend(rf_pend), .cmp_q(cmp_q)
    );

    xbus_seq #(.BEATS(BEATS)) u_seq (
        .clk(clk), .por(por), .mrst(mrst), .slave_mode(slave_mode),
        .dma_req(dma_req), .dma_burst(dma_burst),
        .cpu_req(cpu_req), .cpu_burst(cpu_burst),
        .brq(brq), .self_ref(self_ref), .mem_ack(mem_ack),
        .rf_pend(rf_pend), .rf_take(rf_take),
        .st(st), .ctx(ctx), .beat(beat)
    );

    assign cyc_on  = (st == ST_XFER) && !por;
    assign cyc_dma = cyc_on && ctx.own_dma;
    assign beat_no = por ? 2'b00 : 2'(beat);
    assign rfsh_on = (st == ST_RFSH) && !por;
    assign rel_ack = (st == ST_REL) && !por && !mrst;
    assign drv_en  = !(por && slave_mode) && (st != ST_REL);

    p_por_quiet_r1: assert property (@(posedge clk)
        por |-> !(cyc_on || rfsh_on || rel_ack || cyc_dma));
    p_slave_drv_r2: assert property (@(posedge clk)
        (por && slave_mode) |-> !drv_en);
    p_relack_mrst_r10: assert property (@(posedge clk)
        mrst |-> !rel_ack);
    p_excl_r9: assert property (@(posedge clk) disable iff (por)
        $onehot0({cyc_on, rfsh_on, rel_ack}));
    p_cmp_keep_r3: assert property (@(posedge clk) disable iff (por)
        (mrst && !cfg_we) |=> $stable(cmp_q));

endmodule

// File: tb/xbus_ctrl_bench.sv
module xbus_ctrl_bench;
    localparam int            CW  = 8;
    localparam logic [CW-1:0] DEF = 8'd40;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic por = 1'b1, mrst = 1'b0, slave_mode = 1'b0;
    logic dma_req = 1'b0, dma_burst = 1'b0, cpu_req = 1'b0, cpu_burst = 1'b0;
    logic brq = 1'b0, self_ref = 1'b0, mem_ack = 1'b0, cfg_we = 1'b0;
    logic [CW-1:0] cfg_wdata = '0;
    logic cyc_on, cyc_dma, rfsh_on, drv_en, rel_ack;
    logic [1:0] beat_no;
    logic [CW-1:0] cmp_q;

    xbus_ctrl #(.CW(CW), .RFSH_DEF(DEF)) u_xbus_ctrl (
        .clk(clk), .por(por), .mrst(mrst), .slave_mode(slave_mode),
        .dma_req(dma_req), .dma_burst(dma_burst), .cpu_req(cpu_req),
        .cpu_burst(cpu_burst), .brq(brq), .self_ref(self_ref),
        .mem_ack(mem_ack), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cyc_on(cyc_on), .cyc_dma(cyc_dma), .beat_no(beat_no),
        .rfsh_on(rfsh_on), .drv_en(drv_en), .rel_ack(rel_ack), .cmp_q(cmp_q)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    string tag = "R1";

    // Reference model: states 0 idle, 1 transfer, 2 refresh, 3 released
    int m_st = 0, m_beat = 0;
    bit m_own = 0, m_burst = 0, m_pend = 0;
    int m_cnt = 0, m_cmp = int'(DEF);

    always @(posedge clk) begin
        int  st_n, beat_n, cnt_n, cmp_n;
        bit  own_n, burst_n, pend_n, take;
        if (por) begin
            m_st = 0; m_beat = 0; m_own = 0; m_burst = 0;
            m_pend = 0; m_cnt = 0; m_cmp = int'(DEF);
        end else begin
            st_n = m_st; beat_n = m_beat; own_n = m_own; burst_n = m_burst;
            take = 0;
            case (m_st)
                0: if (brq && !slave_mode && !self_ref) st_n = 3;
                   else if (m_pend) begin st_n = 2; take = 1; end
                   else if (!mrst && dma_req) begin st_n = 1; own_n = 1; burst_n = dma_burst; beat_n = 0; end
                   else if (!mrst && cpu_req) begin st_n = 1; own_n = 0; burst_n = cpu_burst; beat_n = 0; end
                1: if (mem_ack) begin
                       if (m_burst && m_beat != 3 && !mrst) beat_n = m_beat + 1;
                       else begin st_n = 0; beat_n = 0; end
                   end
                2: if (mem_ack) st_n = 0;
                default: if (!brq) st_n = 0;
            endcase
            pend_n = m_pend && !take;
            cnt_n = m_cnt;
            cmp_n = cfg_we ? int'(cfg_wdata) : m_cmp;
            if (!mrst) begin
                if (m_cnt >= m_cmp) begin cnt_n = 0; pend_n = 1; end
                else cnt_n = m_cnt + 1;
            end
            m_st = st_n; m_beat = beat_n; m_own = own_n; m_burst = burst_n;
            m_pend = pend_n; m_cnt = cnt_n; m_cmp = cmp_n;
        end
    end

    task automatic chk1(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // sample at the falling edge, then leave inputs to the caller
    task automatic tick();
        @(negedge clk);
        chk1("cyc_on",  int'(cyc_on),  int'(m_st == 1 && !por));
        chk1("cyc_dma", int'(cyc_dma), int'(m_st == 1 && !por && m_own));
        chk1("beat_no", int'(beat_no), por ? 0 : m_beat);
        chk1("rfsh_on", int'(rfsh_on), int'(m_st == 2 && !por));
        chk1("rel_ack", int'(rel_ack), int'(m_st == 3 && !por && !mrst));
        chk1("drv_en",  int'(drv_en),  int'(!(por && slave_mode) && m_st != 3));
        chk1("cmp_q",   int'(cmp_q),   m_cmp);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_up();
    end

    initial begin
        void'($urandom(32'd1234));
        // R1 R2: reset state in slave mode, drivers off at once
        tag = "R2"; slave_mode = 1; run(3);
        @(negedge clk); por = 0; run(2);
        tag = "R1"; slave_mode = 0;
        dma_req = 1; dma_burst = 1; run(2);
        por = 1; run(1);                      // strobes drop in the same cycle
        por = 0; dma_req = 0; run(2);
        // R3: limit survives manual reset, restored by power-on reset
        tag = "R3"; cfg_we = 1; cfg_wdata = 8'd12; run(1);
        cfg_we = 0; mrst = 1; run(4); mrst = 0; run(1);
        por = 1; run(1); por = 0; run(1);
        cfg_we = 1; cfg_wdata = 8'd10; run(1); cfg_we = 0;
        // R7: refresh fires and beats a waiting CPU request; R6 freeze
        tag = "R7"; cpu_req = 1; run(14); mem_ack = 1; run(1); mem_ack = 0;
        cpu_req = 0; run(3);
        tag = "R6"; mrst = 1; run(30); mrst = 0; run(14); mem_ack = 1; run(1); mem_ack = 0;
        // R9: DMA wins over CPU
        tag = "R9"; dma_req = 1; cpu_req = 1; dma_burst = 0; run(2);
        mem_ack = 1; run(1); dma_req = 0; run(1); mem_ack = 0; cpu_req = 0; run(2);
        // R8: burst holds beat without ack, counts 0..3
        tag = "R8"; cpu_req = 1; cpu_burst = 1; run(1); cpu_req = 0; run(3);
        for (int b = 0; b < 4; b++) begin mem_ack = 1; run(1); mem_ack = 0; run(1); end
        // R4 R5: manual reset truncates burst after current beat, no new start
        tag = "R5"; dma_req = 1; dma_burst = 1; run(1); dma_req = 0;
        mem_ack = 1; run(1); mem_ack = 0; mrst = 1; run(2);
        tag = "R4"; dma_req = 1; mem_ack = 1; run(1); mem_ack = 0; run(4);
        mrst = 0; dma_req = 0; run(1); mem_ack = 1; run(2); mem_ack = 0;
        // R10: release during manual reset, ack hidden, bus held
        tag = "R10"; mrst = 1; brq = 1; run(4); mrst = 0; run(2);
        mrst = 1; run(2); mrst = 0; brq = 0; run(2);
        // R11: self-refresh and slave mode hold off release
        tag = "R11"; self_ref = 1; brq = 1; run(4); self_ref = 0;
        slave_mode = 1; run(3); slave_mode = 0; run(2); brq = 0; run(2);
        mem_ack = 1; run(2); mem_ack = 0;
        // random mix
        tag = "RND";
        for (int k = 0; k < 6000; k++) begin
            por       = ($urandom % 500) == 0;
            if (($urandom % 80) == 0) mrst = !mrst;
            if (($urandom % 60) == 0) brq = !brq;
            if (($urandom % 150) == 0) self_ref = !self_ref;
            if (por && ($urandom % 2) == 0) slave_mode = !slave_mode;
            dma_req   = ($urandom % 4) == 0;
            cpu_req   = ($urandom % 3) == 0;
            dma_burst = $urandom % 2;
            cpu_burst = $urandom % 2;
            mem_ack   = $urandom % 2;
            cfg_we    = ($urandom % 300) == 0;
            cfg_wdata = CW'(4 + $urandom % 30);
            tick();
        end
        finish_up();
    end
endmodule